// File: doc/BRIEF.md
# Set Relation Image Operator

This block maps a set of attribute values over one finite universe onto a set over a second universe, through a fixed binary relation fixed at elaboration time. A set is a bit vector: one bit per element of its universe, set when the element is a member. The relation is a bit matrix with one row per element of the first universe (size N1) and one column per element of the second universe (size N2). It is passed in as a single flattened parameter vector.

In image mode the block takes a set over the first universe and returns every element of the second universe that is related to at least one member of the input. In pre-image mode it takes a set over the second universe and returns every element of the first universe related to at least one member. Both modes read the same parameter; the pre-image mode reads it transposed. The block has no clock and no state. Several instances can be chained to compose relations, and the chain gives the same result as one instance built from the composed matrix.

Top module: `relimg_op`

## Requirements
- R1: A set over a universe of K elements is a K-bit vector whose bit i is 1 exactly when element i is a member. In image mode `set_in` has N1 bits and `set_out` has N2 bits. In pre-image mode `set_in` has N2 bits and `set_out` has N1 bits.
- R2: The relation parameter is N1*N2 bits wide. The pair (x,y) is related when bit x*N2+y of the parameter is 1, counting from the least significant bit.
- R3: In image mode, `set_out[y]` is 1 exactly when some x has both `set_in[x]` and pair (x,y) set.
- R4: In pre-image mode, `set_out[x]` is 1 exactly when some y has both `set_in[y]` and pair (x,y) set. This mode uses the same parameter as image mode.
- R5: An empty input set gives an empty output set in both modes.
- R6: The output follows the input with no clock. A new input value appears at the output with no clock edge in between.
- R7: Feeding the image under relation F into an image under relation G gives the same set as one image under H. Here H(x,z) is 1 when some y has both F(x,y) and G(y,z).
- R8: With N1=7, N2=2 and the flattened relation 14'b11101010001010, element 2 relates to nothing, element 6 relates to both outputs, and every other element relates only to output element 1.
- R9: The output never holds an element that has no related pair. An input that holds only elements with no related pair gives an empty output. A full input gives exactly the set of all elements that have a related pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| set_in | input | N1 in image mode, N2 in pre-image mode | Source set, one bit per element |
| set_out | output | N2 in image mode, N1 in pre-image mode | Resulting image or pre-image set |

## Verification
The checker watches every change of the ports for behaviour that holds whatever the input is. An empty input must give an empty output. The output must stay inside the set of elements that take part in the relation. An input made only of elements that take part in no pair must give nothing, and a full input must give exactly that set. Exact bit-for-bit results can only be shown by the bench scenarios. These are the sample 7-by-2 relation in both modes, exhaustive sweeps of every input compared with a reference model for two matrix sizes, and a check that a chain of two images equals one image under the composed matrix.

// File: rtl/relimg_pkg.sv
package relimg_pkg;

    // Which way the matrix is applied
    typedef enum logic {
        DIR_IMAGE    = 1'b0,
        DIR_PREIMAGE = 1'b1
    } relimg_dir_e;

    // Position of pair (x,y) inside the flattened matrix, row-major
    function automatic int relimg_pos(input int x, input int y, input int n2);
        return x * n2 + y;
    endfunction

    // Width of the source set for a given direction
    function automatic int relimg_src_w(input relimg_dir_e dir, input int n1, input int n2);
        return (dir == DIR_IMAGE) ? n1 : n2;
    endfunction

    // Width of the resulting set for a given direction
    function automatic int relimg_dst_w(input relimg_dir_e dir, input int n1, input int n2);
        return (dir == DIR_IMAGE) ? n2 : n1;
    endfunction

endpackage

// File: rtl/relimg_image.sv
module relimg_image #(
    parameter int              N1  = 7,
    parameter int              N2  = 2,
    parameter logic [N1*N2-1:0] REL = '0
) (
    input  logic [N1-1:0] src,
    output logic [N2-1:0] dst
);
    import relimg_pkg::*;

    // One column of the matrix per output element, then an AND-OR reduction
    for (genvar gy = 0; gy < N2; gy++) begin : g_col
        logic [N1-1:0] col;
        for (genvar gx = 0; gx < N1; gx++) begin : g_row
            assign col[gx] = REL[relimg_pos(gx, gy, N2)];
        end
        assign dst[gy] = |(src & col);
    end

endmodule

// File: rtl/relimg_preimage.sv
module relimg_preimage #(
    parameter int              N1  = 7,
    parameter int              N2  = 2,
    parameter logic [N1*N2-1:0] REL = '0
) (
    input  logic [N2-1:0] src,
    output logic [N1-1:0] dst
);
    import relimg_pkg::*;

    // A row of the flattened matrix is contiguous, so each output bit
    // reads one slice of the shared parameter
    for (genvar gx = 0; gx < N1; gx++) begin : g_row
        localparam logic [N2-1:0] ROW = REL[relimg_pos(gx, 0, N2) +: N2];
        assign dst[gx] = |(src & ROW);
    end

endmodule

// File: rtl/relimg_op.sv
module relimg_op
    import relimg_pkg::*;
#(
    parameter int               N1        = 7,
    parameter int               N2        = 2,
    parameter logic [N1*N2-1:0] RELATION  = 14'b11101010001010,
    parameter relimg_dir_e      DIRECTION = DIR_IMAGE,
    localparam int              IN_W      = relimg_src_w(DIRECTION, N1, N2),
    localparam int              OUT_W     = relimg_dst_w(DIRECTION, N1, N2)
) (
    input  logic [IN_W-1:0]  set_in,
    output logic [OUT_W-1:0] set_out
);

    if (DIRECTION == DIR_IMAGE) begin : g_fwd
        relimg_image #(
            .N1  (N1),
            .N2  (N2),
            .REL (RELATION)
        ) u_img (
            .src (set_in),
            .dst (set_out)
        );
    end else begin : g_inv
        relimg_preimage #(
            .N1  (N1),
            .N2  (N2),
            .REL (RELATION)
        ) u_pre (
            .src (set_in),
            .dst (set_out)
        );
    end

endmodule

// File: rtl/relimg_chk.sv
module relimg_chk
    import relimg_pkg::*;
#(
    parameter int               N1        = 7,
    parameter int               N2        = 2,
    parameter logic [N1*N2-1:0] RELATION  = '0,
    parameter relimg_dir_e      DIRECTION = DIR_IMAGE,
    localparam int              IN_W      = relimg_src_w(DIRECTION, N1, N2),
    localparam int              OUT_W     = relimg_dst_w(DIRECTION, N1, N2)
) (
    input logic [IN_W-1:0]  set_in,
    input logic [OUT_W-1:0] set_out
);

    // Elements of each universe that take part in at least one pair
    logic [N1-1:0] row_any;
    logic [N2-1:0] col_any;
    always_comb begin
        row_any = '0;
        col_any = '0;
        for (int x = 0; x < N1; x++) begin
            for (int y = 0; y < N2; y++) begin
                if (RELATION[x*N2+y]) begin
                    row_any[x] = 1'b1;
                    col_any[y] = 1'b1;
                end
            end
        end
    end

    logic [IN_W-1:0]  live_in;
    logic [OUT_W-1:0] reach_out;
    if (DIRECTION == DIR_IMAGE) begin : g_fwd
        assign live_in   = row_any;
        assign reach_out = col_any;
    end else begin : g_inv
        assign live_in   = col_any;
        assign reach_out = row_any;
    end

    always_comb begin
        // R5
        if (set_in == '0) begin
            empty_map_chk: assert (set_out == '0)
                else $error("empty input produced %b", set_out);
        end
        // R9
        outside_reach_chk: assert ((set_out & ~reach_out) == '0)
            else $error("output %b leaves reachable set %b", set_out, reach_out);
        // R9
        if ((set_in & live_in) == '0) begin
            dead_input_chk: assert (set_out == '0)
                else $error("unrelated input %b produced %b", set_in, set_out);
        end
        // R9
        if (&set_in) begin
            full_input_chk: assert (set_out == reach_out)
                else $error("full input gave %b, expected %b", set_out, reach_out);
        end
    end

endmodule

bind relimg_op relimg_chk #(
    .N1        (N1),
    .N2        (N2),
    .RELATION  (RELATION),
    .DIRECTION (DIRECTION)
) u_chk (
    .set_in  (set_in),
    .set_out (set_out)
);

// File: tb/sim_relimg_op.sv
module sim_relimg_op;
    import relimg_pkg::*;

    localparam logic [13:0] REL_EX = 14'b11101010001010;
    localparam logic [11:0] REL_A  = 12'b1001_0110_0001; // 3x4
    localparam logic [11:0] REL_B  = 12'b010_110_000_101; // 4x3

    // Reference composition: H(x,z) = OR_y F(x,y) & G(y,z)
    function automatic logic [63:0] compose(input logic [63:0] f, input logic [63:0] g,
                                            input int n1, input int n2, input int n3);
        logic [63:0] h = '0;
        for (int x = 0; x < n1; x++)
            for (int z = 0; z < n3; z++)
                for (int y = 0; y < n2; y++)
                    if (f[x*n2+y] && g[y*n3+z]) h[x*n3+z] = 1'b1;
        return h;
    endfunction

    localparam logic [63:0] REL_C_FULL = compose(64'(REL_A), 64'(REL_B), 3, 4, 3);
    localparam logic [8:0]  REL_C      = REL_C_FULL[8:0];

    // Reference image / pre-image
    function automatic logic [63:0] ref_map(input logic [63:0] rel, input logic [63:0] s,
                                            input int n1, input int n2, input bit inv);
        logic [63:0] r = '0;
        for (int x = 0; x < n1; x++)
            for (int y = 0; y < n2; y++)
                if (rel[x*n2+y]) begin
                    if (!inv && s[x]) r[y] = 1'b1;
                    if (inv && s[y])  r[x] = 1'b1;
                end
        return r;
    endfunction

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [6:0] a7;
    logic [1:0] b2;
    logic [2:0] c3;
    logic [3:0] d4;
    logic [1:0] a_out;
    logic [6:0] b_out;
    logic [3:0] c_mid;
    logic [2:0] d_out;
    logic [2:0] c_chain;
    logic [2:0] c_direct;

    relimg_op #(.N1(7), .N2(2), .RELATION(REL_EX), .DIRECTION(DIR_IMAGE))
        u0 (.set_in(a7), .set_out(a_out));
    relimg_op #(.N1(7), .N2(2), .RELATION(REL_EX), .DIRECTION(DIR_PREIMAGE))
        u1 (.set_in(b2), .set_out(b_out));
    relimg_op #(.N1(3), .N2(4), .RELATION(REL_A), .DIRECTION(DIR_IMAGE))
        u2 (.set_in(c3), .set_out(c_mid));
    relimg_op #(.N1(3), .N2(4), .RELATION(REL_A), .DIRECTION(DIR_PREIMAGE))
        u3 (.set_in(d4), .set_out(d_out));
    relimg_op #(.N1(4), .N2(3), .RELATION(REL_B), .DIRECTION(DIR_IMAGE))
        u4 (.set_in(c_mid), .set_out(c_chain));
    relimg_op #(.N1(3), .N2(3), .RELATION(REL_C), .DIRECTION(DIR_IMAGE))
        u5 (.set_in(c3), .set_out(c_direct));

    int checks = 0;
    int errors = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_all(input logic [6:0] va, input logic [1:0] vb,
                             input logic [2:0] vc, input logic [3:0] vd);
        @(posedge clk);
        a7 = va; b2 = vb; c3 = vc; d4 = vd;
        @(negedge clk);
    endtask

    // Output at start with all inputs empty (R5)
    task automatic t_reset_state;
        drive_all('0, '0, '0, '0);
        check("R5 image empty",     64'(a_out), 64'd0);
        check("R5 preimage empty",  64'(b_out), 64'd0);
        check("R5 small preimage",  64'(d_out), 64'd0);
        check("R5 chain empty",     64'(c_chain), 64'd0);
    endtask

    // Sample 7x2 relation, image mode (R8, R3, R2)
    task automatic t_example_image;
        drive_all(7'b0000001, '0, '0, '0);
        check("R8 x0 -> y1",        64'(a_out), 64'b10);
        drive_all(7'b1000000, '0, '0, '0);
        check("R8 x6 -> both",      64'(a_out), 64'b11);
        drive_all(7'b0000100, '0, '0, '0);
        check("R8 x2 -> none",      64'(a_out), 64'b00);
        drive_all(7'b1111111, '0, '0, '0);
        check("R9 full image",      64'(a_out), 64'b11);
    endtask

    // Sample 7x2 relation, pre-image mode (R8, R4)
    task automatic t_example_preimage;
        drive_all('0, 2'b01, '0, '0);
        check("R8 y0 <- x6",        64'(b_out), 64'b1000000);
        drive_all('0, 2'b10, '0, '0);
        check("R4 y1 preimage",     64'(b_out), 64'b1111011);
        drive_all('0, 2'b11, '0, '0);
        check("R9 full preimage",   64'(b_out), 64'b1111011);
    endtask

    // No clock edge between input change and output (R6)
    task automatic t_comb;
        @(negedge clk);
        a7 = 7'b0000100;
        #0.5;
        check("R6 settle a", 64'(a_out), 64'b00);
        a7 = 7'b1000000;
        #0.5;
        check("R6 settle b", 64'(a_out), 64'b11);
    endtask

    // Exhaustive sweeps against the reference (R1, R3, R4)
    task automatic t_sweep;
        for (int v = 0; v < 128; v++) begin
            drive_all(7'(v), 2'(v), 3'(v), 4'(v));
            check("R3 sweep 7x2", 64'(a_out), ref_map(64'(REL_EX), 64'(v), 7, 2, 1'b0));
            if (v < 4)
                check("R4 sweep 7x2", 64'(b_out), ref_map(64'(REL_EX), 64'(v), 7, 2, 1'b1));
            if (v < 8)
                check("R3 sweep 3x4", 64'(c_mid), ref_map(64'(REL_A), 64'(v), 3, 4, 1'b0));
            if (v < 16)
                check("R4 sweep 3x4", 64'(d_out), ref_map(64'(REL_A), 64'(v), 3, 4, 1'b1));
        end
    endtask

    // Chain of two images equals one image under the composed kernel (R7)
    task automatic t_compose;
        for (int v = 0; v < 8; v++) begin
            drive_all('0, '0, 3'(v), '0);
            check("R7 chain vs direct", 64'(c_chain), 64'(c_direct));
            check("R7 direct vs ref",   64'(c_direct), ref_map(REL_C_FULL, 64'(v), 3, 3, 1'b0));
        end
    endtask

    initial begin
        a7 = '0; b2 = '0; c3 = '0; d4 = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_example_image();
        t_example_preimage();
        t_comb();
        t_sweep();
        t_compose();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule